// File: doc/BRIEF.md
# PLL Feedback Multiplier Code Converter

This block translates between a plain binary PLL feedback multiplier and the scrambled 17-bit code that the PLL's multiplier field expects. In that code, a multiplier is the position of a state in a 15-bit shift-register sequence. Multipliers 1 and 2 use fixed special codes, and multiplier 0 maps to an all-zero code. The converter walks the sequence one step per clock. An encode walks forward from the seed state. A decode walks backward until it reaches the seed, counting down from one above the largest multiplier.

Every response carries a packed multiplier word. The word holds three things:
- the code;
- a proportional loop-bandwidth value;
- an integral loop-bandwidth value.

Both bandwidth values are always derived from the binary multiplier: the requested one on an encode, and the recovered one on a decode. The PLL runs at 2·m times its input frequency when it is not bypassed and both of its dividers are 1. A single request port takes a mode bit, a multiplier and a code. A single response port returns the word, the binary multiplier and an invalid-code flag. Both ports use valid/ready handshakes.

Top module: `mlfsr_codec`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: Encoding multipliers 0, 1 and 2 gives codes 0x00000, 0x18003 and 0x10003. The response is valid right after the accepting edge, with no step cycles.
- R3: Encoding any other m ≤ 32768 starts from state 0x4000 and applies 32768 − m + 1 forward steps. A forward step forms feedback = bit0 XOR bit1, shifts the state right by one and places the feedback in bit 14. Encoding 32768 gives 0x2000.
- R4: Encoding a multiplier above 32768 applies no step and returns code 0x4000.
- R5: Decoding code 0x18003 returns 1 and decoding code 0x10003 returns 2, with no step cycles.
- R6: Decoding any other code starts a counter at 32769. Each cycle it checks whether the state equals 0x4000. If not, it applies one backward step and decrements the counter. A backward step forms feedback = bit0 XOR bit14, shifts the low 15 bits left and places the feedback in bit 0. The final counter is the result, so code 0x4000 returns 32769 and code 0x2000 returns 32768.
- R7: If a decode exhausts the counter without reaching 0x4000 (for example, code 0), the result is 0 and `rsp_invalid_o` is 1. Every other response has `rsp_invalid_o` at 0.
- R8: The proportional value is (m >> 1) + 1 for m < 60 and 31 otherwise.
- R9: The integral value depends on m as follows:
  - 1 for m > 16384;
  - 2 for m > 8192;
  - 4 for m > 2048;
  - 8 for m ≥ 501;
  - 4·ceil(1024/(m+9)) for 60 ≤ m ≤ 500;
  - (m & 0x3C) + 4 below 60.
- R10: `rsp_word_o` has the following layout:
  - bits 16:0 hold the code;
  - bits 21:17 hold the proportional value;
  - bits 27:22 hold the integral value;
  - bits 31:28 are 0.
  
  `rsp_mult_o` carries the binary multiplier, which is the requested one on an encode and the recovered one on a decode.
- R11: A stepping request takes one clock per step plus one, counted in rising edges from the accepting edge to the first edge after which `rsp_valid_o` is 1. An encode of m ≤ 32768 therefore takes 32768 − m + 2 edges, and an encode above 32768 takes 1.
- R12: `req_ready_o` is 1 only while no request is in flight, so a request offered during a conversion is not taken. A response stays valid and unchanged until `rsp_ready_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Converter idle, request taken this cycle |
| req_dec_i | input | 1 | 1 = decode a code, 0 = encode a multiplier |
| req_mult_i | input | 16 | Binary multiplier to encode |
| req_code_i | input | 17 | Code to decode |
| rsp_valid_o | output | 1 | Response available |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_word_o | output | 32 | Packed code plus bandwidth word |
| rsp_mult_o | output | 16 | Binary multiplier |
| rsp_invalid_o | output | 1 | Decode found no matching sequence position |

## Verification
Directed requests cover the special codes, the top of the range (one step), multipliers beyond the range (zero steps) and the seed code itself. These cases separate the special-case path from the stepping path and expose any off-by-one in the step count. Long walks at m = 3, 60, 16384 and 16385, together with the all-zero code, check the integral and proportional thresholds and the invalid path. Random multipliers near the top of the range are encoded, and random codes drawn from the same range are decoded. Both are compared against bench models of the sequence, which tells a wrong feedback tap or shift direction apart from a wrong counter. A held response and a request offered mid-conversion test the handshake.

// File: rtl/mlfsr_pkg.sv
package mlfsr_pkg;
  localparam int unsigned CODE_W   = 17;
  localparam int unsigned SELP_W   = 5;
  localparam int unsigned SELI_W   = 6;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SELP_LSB = 17;
  localparam int unsigned SELI_LSB = 22;

  localparam logic [CODE_W-1:0] CODE_ONE = 17'h18003;
  localparam logic [CODE_W-1:0] CODE_TWO = 17'h10003;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_RESP
  } ctl_st_e;

  typedef struct packed {
    logic [SELI_W-1:0] seli;
    logic [SELP_W-1:0] selp;
  } bw_t;
endpackage

// File: rtl/mlfsr_step.sv
module mlfsr_step #(
  parameter int unsigned CODE_W  = 17,
  parameter int unsigned LFSR_W  = 15,
  parameter bit          INVERSE = 1'b0
) (
  input  logic [(INVERSE ? LFSR_W : CODE_W)-1:0] cur_i,
  output logic [CODE_W-1:0]                      nxt_o
);
  localparam int unsigned PAD = CODE_W - LFSR_W;

  if (INVERSE) begin : g_inv
    // walk toward the seed: shift left, feedback into bit 0
    assign nxt_o = {{PAD{1'b0}}, cur_i[LFSR_W-2:0], cur_i[0] ^ cur_i[LFSR_W-1]};
  end else begin : g_fwd
    // walk away from the seed: shift right, feedback into the top state bit
    logic fb;
    assign fb    = cur_i[0] ^ cur_i[1];
    assign nxt_o = (cur_i >> 1) | (CODE_W'(fb) << (LFSR_W - 1));
  end
endmodule

// File: rtl/mlfsr_bw.sv
module mlfsr_bw #(
  parameter int unsigned MUL_W  = 16,
  parameter int unsigned SELP_W = 5,
  parameter int unsigned SELI_W = 6
) (
  input  logic [MUL_W-1:0]  mult_i,
  output logic [SELP_W-1:0] selp_o,
  output logic [SELI_W-1:0] seli_o
);
  // ceil(1024/(m+9)) for m >= 60 never exceeds 15
  localparam int unsigned QN   = 15;
  localparam int unsigned PW   = MUL_W + 5;
  localparam int unsigned CW   = $clog2(QN + 2);

  logic [MUL_W:0]  div_d;
  logic [QN-1:0]   under;
  logic [CW-1:0]   ceil_q;

  assign div_d = {1'b0, mult_i} + (MUL_W + 1)'(9);

  for (genvar q = 1; q <= QN; q++) begin : g_quot
    logic [PW-1:0] prod;
    assign prod         = PW'(q) * PW'(div_d);
    assign under[q-1]   = prod < PW'(1024);
  end

  assign ceil_q = CW'($countones(under)) + CW'(1);

  always_comb begin
    if (mult_i < MUL_W'(60)) selp_o = SELP_W'(mult_i[5:1]) + SELP_W'(1);
    else                     selp_o = SELP_W'(31);

    if      (mult_i > MUL_W'(16384)) seli_o = SELI_W'(1);
    else if (mult_i > MUL_W'(8192))  seli_o = SELI_W'(2);
    else if (mult_i > MUL_W'(2048))  seli_o = SELI_W'(4);
    else if (mult_i >= MUL_W'(501))  seli_o = SELI_W'(8);
    else if (mult_i >= MUL_W'(60))   seli_o = SELI_W'({ceil_q, 2'b00});
    else                             seli_o = SELI_W'(mult_i[5:0] & 6'h3c) + SELI_W'(4);
  end
endmodule

// File: rtl/mlfsr_engine.sv
module mlfsr_engine #(
  parameter int unsigned CODE_W = 17,
  parameter int unsigned LFSR_W = 15,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              inv_i,
  input  logic [CODE_W-1:0] load_state_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] state_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CODE_W-1:0] SEED = CODE_W'(1) << (LFSR_W - 1);

  logic              busy_q, inv_q, hit;
  logic [CODE_W-1:0] state_q, fwd_nxt, inv_nxt;
  logic [CNT_W-1:0]  cnt_q;

  mlfsr_step #(.CODE_W(CODE_W), .LFSR_W(LFSR_W), .INVERSE(1'b0)) u_fwd (
    .cur_i(state_q),
    .nxt_o(fwd_nxt)
  );

  mlfsr_step #(.CODE_W(CODE_W), .LFSR_W(LFSR_W), .INVERSE(1'b1)) u_inv (
    .cur_i(state_q[LFSR_W-1:0]),
    .nxt_o(inv_nxt)
  );

  // forward walk ends on step count, backward walk also on reaching the seed
  assign hit    = inv_q ? ((state_q == SEED) || (cnt_q == '0)) : (cnt_q == '0);
  assign done_o = busy_q && hit;
  assign busy_o = busy_q;
  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      inv_q   <= 1'b0;
      state_q <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      inv_q   <= inv_i;
      state_q <= load_state_i;
      cnt_q   <= load_cnt_i;
    end else if (busy_q) begin
      if (hit) begin
        busy_q <= 1'b0;
      end else begin
        state_q <= inv_q ? inv_nxt : fwd_nxt;
        cnt_q   <= cnt_q - CNT_W'(1);
      end
    end
  end

  AST_ONE_STEP_PER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !hit && !start_i |=> cnt_q == $past(cnt_q) - CNT_W'(1)) else $error("step"); // R11
  AST_FWD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !inv_q |-> state_q != '0) else $error("fwd zero"); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q) else $error("restart"); // R12
endmodule

// File: rtl/mlfsr_codec.sv
module mlfsr_codec
  import mlfsr_pkg::*;
#(
  parameter int unsigned LFSR_W = 15,
  parameter int unsigned MUL_W  = LFSR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_dec_i,
  input  logic [MUL_W-1:0]  req_mult_i,
  input  logic [CODE_W-1:0] req_code_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [WORD_W-1:0] rsp_word_o,
  output logic [MUL_W-1:0]  rsp_mult_o,
  output logic              rsp_invalid_o
);
  localparam logic [MUL_W-1:0]  MAX_M = MUL_W'(1) << LFSR_W;
  localparam logic [CODE_W-1:0] SEED  = CODE_W'(1) << (LFSR_W - 1);
  localparam int unsigned       PADW  = WORD_W - SELI_LSB - SELI_W;

  ctl_st_e           st_q;
  logic              dec_q, inval_q;
  logic [CODE_W-1:0] code_q;
  logic [MUL_W-1:0]  mult_q;

  logic              accept, enc_special, dec_special, eng_start;
  logic              eng_busy, eng_done;
  logic [CODE_W-1:0] eng_state, eng_load_state;
  logic [MUL_W-1:0]  eng_cnt, eng_load_cnt;
  bw_t               bw;

  assign accept      = req_valid_i && (st_q == ST_IDLE);
  assign enc_special = req_mult_i <= MUL_W'(2);
  assign dec_special = (req_code_i == CODE_ONE) || (req_code_i == CODE_TWO);
  assign eng_start   = accept && (req_dec_i ? !dec_special : !enc_special);

  always_comb begin
    if (req_dec_i) begin
      eng_load_state = req_code_i;
      eng_load_cnt   = MAX_M + MUL_W'(1);
    end else begin
      eng_load_state = SEED;
      eng_load_cnt   = (req_mult_i > MAX_M) ? '0 : (MAX_M - req_mult_i + MUL_W'(1));
    end
  end

  mlfsr_engine #(.CODE_W(CODE_W), .LFSR_W(LFSR_W), .CNT_W(MUL_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (eng_start),
    .inv_i       (req_dec_i),
    .load_state_i(eng_load_state),
    .load_cnt_i  (eng_load_cnt),
    .busy_o      (eng_busy),
    .done_o      (eng_done),
    .state_o     (eng_state),
    .cnt_o       (eng_cnt)
  );

  mlfsr_bw #(.MUL_W(MUL_W), .SELP_W(SELP_W), .SELI_W(SELI_W)) u_bw (
    .mult_i(mult_q),
    .selp_o(bw.selp),
    .seli_o(bw.seli)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dec_q   <= 1'b0;
      inval_q <= 1'b0;
      code_q  <= '0;
      mult_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          dec_q   <= req_dec_i;
          inval_q <= 1'b0;
          if (req_dec_i) begin
            code_q <= req_code_i;
            mult_q <= (req_code_i == CODE_ONE) ? MUL_W'(1) : MUL_W'(2);
            st_q   <= dec_special ? ST_RESP : ST_RUN;
          end else begin
            mult_q <= req_mult_i;
            unique case (req_mult_i[1:0])
              2'd1:    code_q <= CODE_ONE;
              2'd2:    code_q <= CODE_TWO;
              default: code_q <= '0;
            endcase
            st_q <= enc_special ? ST_RESP : ST_RUN;
          end
        end
        ST_RUN: if (eng_done) begin
          if (dec_q) begin
            mult_q  <= eng_cnt;
            inval_q <= (eng_cnt == '0);
          end else begin
            code_q <= eng_state;
          end
          st_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign rsp_valid_o   = (st_q == ST_RESP);
  assign rsp_mult_o    = mult_q;
  assign rsp_invalid_o = inval_q;
  assign rsp_word_o    = {{PADW{1'b0}}, bw.seli, bw.selp, code_q};

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_word_o)
      && $stable(rsp_mult_o) && $stable(rsp_invalid_o)) else $error("hold"); // R12
  AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_invalid_o |-> rsp_mult_o == '0) else $error("invalid"); // R7
  AST_ENC_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !dec_q && mult_q == MAX_M |-> code_q == (SEED >> 1)) else $error("top"); // R3
  AST_SPECIAL_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !req_dec_i && req_mult_i == MUL_W'(1) |=> rsp_valid_o
      && rsp_word_o[CODE_W-1:0] == CODE_ONE) else $error("special"); // R2
  AST_SELI_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_word_o[SELI_LSB +: SELI_W] != '0) else $error("seli"); // R9
  AST_BUSY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy |-> !req_ready_o) else $error("busy"); // R12
endmodule

// File: tb/sim_mlfsr_codec.sv
module sim_mlfsr_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_dec = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_mult = '0;
  logic [16:0] req_code = '0;
  logic        req_ready, rsp_valid, rsp_invalid;
  logic [31:0] rsp_word;
  logic [15:0] rsp_mult;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] g_word;
  int          g_mult, g_lat;
  bit          g_inv;

  always #2 clk = ~clk;

  mlfsr_codec u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_dec_i(req_dec),
    .req_mult_i(req_mult), .req_code_i(req_code),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_word_o(rsp_word), .rsp_mult_o(rsp_mult), .rsp_invalid_o(rsp_invalid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int enc_model(input int m);
    int x;
    if (m == 0) return 0;
    if (m == 1) return 'h18003;
    if (m == 2) return 'h10003;
    x = 'h4000;
    for (int i = m; i <= 32768; i++)
      x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'hffff);
    return x;
  endfunction

  task automatic dec_model(input int code, output int mult, output bit inv, output int steps);
    int x, i;
    steps = 0; inv = 1'b0;
    if (code == 'h18003) begin mult = 1; return; end
    if (code == 'h10003) begin mult = 2; return; end
    x = code; i = 32769;
    while (x != 'h4000 && i > 0) begin
      x = ((x ^ (x >> 14)) & 1) | ((x << 1) & 'h7fff);
      i--; steps++;
    end
    mult = i; inv = (i == 0);
  endtask

  function automatic int selp_f(input int m);
    return (m < 60) ? (m >> 1) + 1 : 31;
  endfunction

  function automatic int seli_f(input int m);
    if (m > 16384) return 1;
    if (m > 8192)  return 2;
    if (m > 2048)  return 4;
    if (m >= 501)  return 8;
    if (m >= 60)   return 4 * ((1024 + m + 9 - 1) / (m + 9));
    return (m & 'h3c) + 4;
  endfunction

  task automatic run_op(input bit dec, input int mult, input int code,
                        input bit hold, input bit poke);
    logic [31:0] w0;
    req_dec = dec; req_mult = 16'(mult); req_code = 17'(code);
    req_valid = 1'b1; rsp_ready = !hold;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    g_lat = 0;
    while (!rsp_valid) begin
      if (poke && g_lat >= 4 && g_lat <= 6) begin
        chk(req_ready == 1'b0, "R12", "ready while busy", req_ready, 0);
        req_valid = 1'b1; req_dec = 1'b1; req_mult = 16'd5; req_code = 17'h0;
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      g_lat++;
    end
    req_valid = 1'b0;
    g_word = rsp_word; g_mult = int'(rsp_mult); g_inv = rsp_invalid;
    if (hold) begin
      w0 = rsp_word;
      repeat (4) begin
        @(posedge clk); @(negedge clk);
        chk(rsp_valid && rsp_word == w0, "R12", "held response", rsp_word, w0);
      end
      rsp_ready = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    if (hold) chk(!rsp_valid && req_ready, "R12", "released", rsp_valid, 0);
  endtask

  task automatic check_bw(input int m, input string tag);
    chk(g_word[21:17] == 5'(selp_f(m)), "R8", {tag, " selp"}, g_word[21:17], selp_f(m));
    chk(g_word[27:22] == 6'(seli_f(m)), "R9", {tag, " seli"}, g_word[27:22], seli_f(m));
    chk(g_word[31:28] == 4'h0, "R10", {tag, " pad"}, g_word[31:28], 0);
  endtask

  task automatic do_enc(input int m, input string req, input bit hold, input bit poke);
    int exp_c, exp_l;
    run_op(1'b0, m, 0, hold, poke);
    exp_c = (m > 32768) ? 'h4000 : enc_model(m);
    exp_l = (m <= 2) ? 0 : (m > 32768) ? 1 : 32768 - m + 2;
    chk(g_word[16:0] == 17'(exp_c), req, "encode code", g_word[16:0], exp_c);
    chk(g_mult == (m & 'hffff) && !g_inv, "R10", "encode mult field", g_mult, m);
    chk(g_lat == exp_l, "R11", "encode latency", g_lat, exp_l);
    check_bw(m & 'hffff, "encode");
  endtask

  task automatic do_dec(input int code, input string req);
    int em, es;
    bit ei;
    run_op(1'b1, 0, code, 1'b0, 1'b0);
    dec_model(code, em, ei, es);
    chk(g_mult == em, req, "decode mult", g_mult, em);
    chk(g_inv == ei, "R7", "invalid flag", g_inv, ei);
    chk(g_word[16:0] == 17'(code), "R10", "decode code field", g_word[16:0], code);
    if (code != 'h18003 && code != 'h10003)
      chk(g_lat == es + 1, "R11", "decode latency", g_lat, es + 1);
    else
      chk(g_lat == 0, "R5", "special decode latency", g_lat, 0);
    check_bw(em, "decode");
  endtask

  initial begin
    void'($urandom(7));
    #1;
    chk(req_ready && !rsp_valid, "R1", "in reset", {req_ready, rsp_valid}, 2);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1", "after reset", {req_ready, rsp_valid}, 2);

    do_enc(0, "R2", 1'b0, 1'b0);
    do_enc(1, "R2", 1'b0, 1'b0);
    do_enc(2, "R2", 1'b0, 1'b0);
    do_enc(32768, "R3", 1'b0, 1'b0);
    chk(g_word[16:0] == 17'h2000, "R3", "top code", g_word[16:0], 'h2000);
    do_enc(32767, "R3", 1'b0, 1'b0);
    do_enc(40000, "R4", 1'b0, 1'b0);
    do_enc(65535, "R4", 1'b0, 1'b0);
    do_dec('h18003, "R5");
    chk(g_mult == 1, "R5", "one", g_mult, 1);
    do_dec('h10003, "R5");
    chk(g_mult == 2, "R5", "two", g_mult, 2);
    do_dec('h2000, "R6");
    chk(g_mult == 32768, "R6", "top decode", g_mult, 32768);
    do_dec('h4000, "R6");
    chk(g_mult == 32769, "R6", "seed decode", g_mult, 32769);
    do_dec(0, "R7");
    chk(g_inv && g_mult == 0, "R7", "zero code invalid", g_mult, 0);
    do_enc(32760, "R3", 1'b1, 1'b0);        // R12 hold
    do_enc(3, "R3", 1'b0, 1'b1);            // R12 request ignored mid-walk
    do_enc(60, "R9", 1'b0, 1'b0);
    do_enc(16384, "R9", 1'b0, 1'b0);
    do_enc(16385, "R9", 1'b0, 1'b0);
    for (int k = 0; k < 20; k++) begin
      int m;
      m = 32768 - int'($urandom % 601);
      do_enc(m, "R3", 1'b0, 1'b0);
      m = 32768 - int'($urandom % 601);
      do_dec(enc_model(m), "R6");
      chk(g_mult == m, "R6", "round trip", g_mult, m);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule